// File: doc/BRIEF.md
# Cache Configuration Energy Estimator

The estimator turns the event counts of one trial cache configuration into a single figure of total memory-access energy. A tuning controller measures hit, miss and cycle counts while the cache runs in a candidate configuration. It then presents those counts together with the configuration code (total size, associativity, line size) and pulses `start_i`. The block picks three per-event energy constants from small internal tables, one set per configuration. It forms hits × hit energy + misses × miss energy + cycles × static energy with one shared multiplier, one product per cycle. It then reports the sum with a one-cycle `done_o` pulse.

Counts and configuration are captured at start, so the caller may change them while the computation runs. The 48-bit sum saturates rather than wrapping. A size/associativity/line code that does not name a buildable cache reports the largest possible energy, so a minimum-seeking search never selects it.

Top module: `cache_energy_est`

## Requirements
- R1: When a computation completes, `energy_o` equals hits × E_hit + misses × E_miss + cycles × E_static, using the counts and configuration sampled with the accepted start.
- R2: E_hit depends on size and associativity. The codes are `size_sel_i` 0 = 2 KB, 1 = 4 KB, 2 = 8 KB and `ways_sel_i` 0 = 1-way, 1 = 2-way, 2 = 4-way. The values are: 2 KB 1-way 3000, 4 KB 1-way 6000, 4 KB 2-way 8000, 8 KB 1-way 10000, 8 KB 2-way 14000, 8 KB 4-way 20000.
- R3: E_miss depends on `line_sel_i`: 0 (16 B) gives 15000, 1 (32 B) gives 30000, 2 (64 B) gives 60000.
- R4: E_static depends on `size_sel_i`: 2 KB gives 250, 4 KB gives 500, 8 KB gives 900.
- R5: `start_i` is accepted on a rising edge while the block is idle. `done_o` is high during the cycle after the fourth rising edge that follows the accepting edge, and low in the three cycles before it.
- R6: `done_o` is a single-cycle pulse.
- R7: A `start_i` that arrives while a computation is in progress is ignored. It produces no additional `done_o` and does not alter the result.
- R8: `energy_o` changes only in the cycle in which `done_o` is high and is held afterwards. Changes to the count and configuration inputs after the accepting edge do not affect the result.
- R9: If the true sum exceeds 2^48 − 1, `energy_o` is 2^48 − 1 (all ones) and does not wrap.
- R10: Any configuration that is not one of the six listed in R2, or a line code of 3, gives `energy_o` equal to all ones. This covers 2 KB 2-way, 2 KB 4-way, 4 KB 4-way, size code 3 and ways code 3.
- R11: While reset is asserted and after it is released, `done_o` is 0 and `energy_o` is 0 until the first completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one estimate |
| hits_i | input | 32 | Hit count |
| misses_i | input | 32 | Miss count |
| cycles_i | input | 32 | Elapsed cycle count |
| size_sel_i | input | 2 | Total size code |
| ways_sel_i | input | 2 | Associativity code |
| line_sel_i | input | 2 | Line size code |
| done_o | output | 1 | One-cycle completion pulse |
| energy_o | output | 48 | Estimated energy, held until the next completion |

## Verification
The properties take for granted that `start_i` is a synchronous level sampled on rising edges. They place no limits on the counts or configuration codes, because every code including the reserved ones has a defined result. Stimulus changes inputs only at falling edges. It spans zero counts, every legal configuration, every reserved code, all-ones counts that force saturation, inputs scrambled after acceptance, and a second start issued while busy. Each expected value is derived from the requirement tables with 64-bit arithmetic.

// File: rtl/cee_pkg.sv
package cee_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned CONST_W = 16;
  localparam int unsigned ACC_W   = 48;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIT,
    ST_MISS,
    ST_STAT,
    ST_FIN
  } cee_state_e;

  localparam logic [1:0] SZ_2K = 2'd0, SZ_4K = 2'd1, SZ_8K = 2'd2;
  localparam logic [1:0] WY_1 = 2'd0, WY_2 = 2'd1, WY_4 = 2'd2;
  localparam logic [1:0] LN_16 = 2'd0, LN_32 = 2'd1, LN_64 = 2'd2;

  localparam logic [CONST_W-1:0] EH_2K1 = 16'd3000;
  localparam logic [CONST_W-1:0] EH_4K1 = 16'd6000;
  localparam logic [CONST_W-1:0] EH_4K2 = 16'd8000;
  localparam logic [CONST_W-1:0] EH_8K1 = 16'd10000;
  localparam logic [CONST_W-1:0] EH_8K2 = 16'd14000;
  localparam logic [CONST_W-1:0] EH_8K4 = 16'd20000;

  localparam logic [CONST_W-1:0] EM_16 = 16'd15000;
  localparam logic [CONST_W-1:0] EM_32 = 16'd30000;
  localparam logic [CONST_W-1:0] EM_64 = 16'd60000;

  localparam logic [CONST_W-1:0] ES_2K = 16'd250;
  localparam logic [CONST_W-1:0] ES_4K = 16'd500;
  localparam logic [CONST_W-1:0] ES_8K = 16'd900;
endpackage

// File: rtl/cee_tables.sv
module cee_tables
  import cee_pkg::*;
(
  input  logic [1:0]         size_i,
  input  logic [1:0]         ways_i,
  input  logic [1:0]         line_i,
  output logic [CONST_W-1:0] e_hit_o,
  output logic [CONST_W-1:0] e_miss_o,
  output logic [CONST_W-1:0] e_stat_o,
  output logic               illegal_o
);
  logic bad_hit, bad_miss, bad_stat;

  always_comb begin
    bad_hit = 1'b0;
    unique case ({size_i, ways_i})
      {SZ_8K, WY_4}: e_hit_o = EH_8K4;
      {SZ_8K, WY_2}: e_hit_o = EH_8K2;
      {SZ_8K, WY_1}: e_hit_o = EH_8K1;
      {SZ_4K, WY_2}: e_hit_o = EH_4K2;
      {SZ_4K, WY_1}: e_hit_o = EH_4K1;
      {SZ_2K, WY_1}: e_hit_o = EH_2K1;
      default: begin
        e_hit_o = '0;
        bad_hit = 1'b1;
      end
    endcase
  end

  always_comb begin
    bad_miss = 1'b0;
    unique case (line_i)
      LN_16:   e_miss_o = EM_16;
      LN_32:   e_miss_o = EM_32;
      LN_64:   e_miss_o = EM_64;
      default: begin
        e_miss_o = '0;
        bad_miss = 1'b1;
      end
    endcase
  end

  always_comb begin
    bad_stat = 1'b0;
    unique case (size_i)
      SZ_2K:   e_stat_o = ES_2K;
      SZ_4K:   e_stat_o = ES_4K;
      SZ_8K:   e_stat_o = ES_8K;
      default: begin
        e_stat_o = '0;
        bad_stat = 1'b1;
      end
    endcase
  end

  assign illegal_o = bad_hit | bad_miss | bad_stat;
endmodule

// File: rtl/cee_seq.sv
module cee_seq
  import cee_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output cee_state_e state_o,
  output logic       accept_o
);
  cee_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_IDLE: state_d = start_i ? ST_HIT : ST_IDLE;
      ST_HIT:  state_d = ST_MISS;
      ST_MISS: state_d = ST_STAT;
      ST_STAT: state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cee_mac.sv
module cee_mac
  import cee_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned CST_W  = 16,
  parameter int unsigned ACC_W  = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cee_state_e       state_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] hits_i,
  input  logic [CNT_W-1:0] misses_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic [CST_W-1:0] e_hit_i,
  input  logic [CST_W-1:0] e_miss_i,
  input  logic [CST_W-1:0] e_stat_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int unsigned PROD_W = CNT_W + CST_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [CNT_W-1:0] op_cnt;
  logic [CST_W-1:0] op_cst;
  logic             op_en;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  prod_fit;
  logic              prod_ovf;
  logic [ACC_W:0]    sum;
  logic [ACC_W-1:0]  acc_q;

  // single shared multiplier, operands steered by sequencer state
  always_comb begin
    op_en = 1'b1;
    unique case (state_i)
      ST_HIT:  begin op_cnt = hits_i;   op_cst = e_hit_i;  end
      ST_MISS: begin op_cnt = misses_i; op_cst = e_miss_i; end
      ST_STAT: begin op_cnt = cycles_i; op_cst = e_stat_i; end
      default: begin op_cnt = '0; op_cst = '0; op_en = 1'b0; end
    endcase
  end

  assign prod = PROD_W'(op_cnt) * PROD_W'(op_cst);

  generate
    if (PROD_W > ACC_W) begin : g_narrow
      assign prod_ovf = |prod[PROD_W-1:ACC_W];
      assign prod_fit = prod[ACC_W-1:0];
    end else begin : g_wide
      assign prod_ovf = 1'b0;
      assign prod_fit = ACC_W'(prod);
    end
  endgenerate

  assign sum = {1'b0, acc_q} + {1'b0, prod_fit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (op_en) begin
      acc_q <= (prod_ovf || sum[ACC_W]) ? ACC_MAX : sum[ACC_W-1:0];
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cache_energy_est.sv
module cache_energy_est
  import cee_pkg::*;
#(
  parameter int unsigned CNT_W = cee_pkg::CNT_W,
  parameter int unsigned ACC_W = cee_pkg::ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] hits_i,
  input  logic [CNT_W-1:0] misses_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic [1:0]       size_sel_i,
  input  logic [1:0]       ways_sel_i,
  input  logic [1:0]       line_sel_i,
  output logic             done_o,
  output logic [ACC_W-1:0] energy_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  cee_state_e state_q;
  logic       accept;

  logic [CNT_W-1:0] hits_q, misses_q, cycles_q;
  logic [1:0]       size_q, ways_q, line_q;

  logic [CONST_W-1:0] e_hit, e_miss, e_stat;
  logic               cfg_illegal;
  logic [ACC_W-1:0]   acc;

  logic             done_q;
  logic [ACC_W-1:0] result_q;

  cee_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state_q),
    .accept_o (accept)
  );

  // capture operands so callers may move on after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q   <= '0;
      misses_q <= '0;
      cycles_q <= '0;
      size_q   <= '0;
      ways_q   <= '0;
      line_q   <= '0;
    end else if (accept) begin
      hits_q   <= hits_i;
      misses_q <= misses_i;
      cycles_q <= cycles_i;
      size_q   <= size_sel_i;
      ways_q   <= ways_sel_i;
      line_q   <= line_sel_i;
    end
  end

  cee_tables u_tables (
    .size_i    (size_q),
    .ways_i    (ways_q),
    .line_i    (line_q),
    .e_hit_o   (e_hit),
    .e_miss_o  (e_miss),
    .e_stat_o  (e_stat),
    .illegal_o (cfg_illegal)
  );

  cee_mac #(
    .CNT_W (CNT_W),
    .CST_W (CONST_W),
    .ACC_W (ACC_W)
  ) u_mac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .clear_i  (accept),
    .hits_i   (hits_q),
    .misses_i (misses_q),
    .cycles_i (cycles_q),
    .e_hit_i  (e_hit),
    .e_miss_i (e_miss),
    .e_stat_i (e_stat),
    .acc_o    (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else if (state_q == ST_FIN) begin
      done_q   <= 1'b1;
      result_q <= cfg_illegal ? ACC_MAX : acc;
    end else begin
      done_q   <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign energy_o = result_q;
endmodule

// File: rtl/cee_checker.sv
module cee_checker
  import cee_pkg::*;
#(
  parameter int unsigned ACC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [ACC_W-1:0] energy_o,
  input cee_state_e       state_q,
  input logic             illegal_q,
  input logic [ACC_W-1:0] acc
);
  // R6
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(energy_o) |-> done_o);

  // R10
  p_illegal_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && illegal_q) |-> (energy_o == '1));

  // R7
  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_HIT));

  // R5
  p_seq_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT) |=> (state_q == ST_MISS));

  // R5
  p_done_from_fin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_FIN));

  // R9
  p_sat_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAT) |=> (acc >= $past(acc)));
endmodule

bind cache_energy_est cee_checker #(.ACC_W(ACC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .energy_o  (energy_o),
  .state_q   (state_q),
  .illegal_q (cfg_illegal),
  .acc       (acc)
);

// File: tb/cache_energy_est_test.sv
module cache_energy_est_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] EMAX = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] hits = '0, misses = '0, cycles = '0;
  logic [1:0]  size_sel = '0, ways_sel = '0, line_sel = '0;
  logic        done;
  logic [47:0] energy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_energy_est uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .hits_i     (hits),
    .misses_i   (misses),
    .cycles_i   (cycles),
    .size_sel_i (size_sel),
    .ways_sel_i (ways_sel),
    .line_sel_i (line_sel),
    .done_o     (done),
    .energy_o   (energy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [31:0] h, input logic [31:0] m,
                                        input logic [31:0] c, input logic [1:0] sz,
                                        input logic [1:0] wy, input logic [1:0] ln);
    longint unsigned eh, em, es, tot;
    bit bad;
    bad = 1'b0; eh = 0; em = 0; es = 0;
    case ({sz, wy})
      4'hA: eh = 20000;
      4'h9: eh = 14000;
      4'h8: eh = 10000;
      4'h5: eh = 8000;
      4'h4: eh = 6000;
      4'h0: eh = 3000;
      default: bad = 1'b1;
    endcase
    case (ln)
      2'd0: em = 15000;
      2'd1: em = 30000;
      2'd2: em = 60000;
      default: bad = 1'b1;
    endcase
    case (sz)
      2'd0: es = 250;
      2'd1: es = 500;
      2'd2: es = 900;
      default: bad = 1'b1;
    endcase
    tot = longint'(h) * eh + longint'(m) * em + longint'(c) * es;
    if (bad || tot > longint'(EMAX)) return EMAX;
    return tot[47:0];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "done with nothing outstanding", 1, 0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(energy == e, t, "energy", energy, e);
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] h, input logic [31:0] m,
                     input logic [31:0] c, input logic [1:0] sz,
                     input logic [1:0] wy, input logic [1:0] ln);
    logic [47:0] e;
    e = model(h, m, c, sz, wy, ln);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    hits = h; misses = m; cycles = c;
    size_sel = sz; ways_sel = wy; line_sel = ln;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble inputs after acceptance
    hits = ~h; misses = ~m; cycles = ~c;
    size_sel = sz ^ 2'd1; ways_sel = wy ^ 2'd2; line_sel = ln ^ 2'd3;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R5", "done early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5", "done latency", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", done, 0);
    repeat (2) @(negedge clk);
    chk(energy == e, "R8", "held result", energy, e);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [47:0] e1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11", "done in reset", done, 0);
    chk(energy == 48'd0, "R11", "energy in reset", energy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
    chk(energy == 48'd0, "R11", "energy after reset", energy, 0);

    run("R1", 32'd0, 32'd0, 32'd0, 2'd2, 2'd2, 2'd0);
    // R2: each hit-energy entry
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd2, 2'd2, 2'd0);
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd2, 2'd1, 2'd0);
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd2, 2'd0, 2'd0);
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd1, 2'd1, 2'd0);
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd1, 2'd0, 2'd0);
    run("R2", 32'd1000, 32'd0, 32'd0, 2'd0, 2'd0, 2'd0);
    // R3: each line size
    run("R3", 32'd0, 32'd100, 32'd0, 2'd2, 2'd0, 2'd0);
    run("R3", 32'd0, 32'd100, 32'd0, 2'd2, 2'd0, 2'd1);
    run("R3", 32'd0, 32'd100, 32'd0, 2'd2, 2'd0, 2'd2);
    // R4: each total size
    run("R4", 32'd0, 32'd0, 32'd1000, 2'd0, 2'd0, 2'd0);
    run("R4", 32'd0, 32'd0, 32'd1000, 2'd1, 2'd0, 2'd0);
    run("R4", 32'd0, 32'd0, 32'd1000, 2'd2, 2'd0, 2'd0);
    // R1: mixed sums
    run("R1", 32'd123456, 32'd789, 32'd500000, 2'd1, 2'd1, 2'd1);
    run("R1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 2'd0, 2'd0);
    // R9: saturation
    run("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 2'd2, 2'd2);
    run("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 2'd2, 2'd1, 2'd2);
    // R10: reserved combinations
    run("R10", 32'd5, 32'd5, 32'd5, 2'd0, 2'd1, 2'd0);
    run("R10", 32'd5, 32'd5, 32'd5, 2'd0, 2'd2, 2'd0);
    run("R10", 32'd5, 32'd5, 32'd5, 2'd1, 2'd2, 2'd1);
    run("R10", 32'd5, 32'd5, 32'd5, 2'd3, 2'd0, 2'd0);
    run("R10", 32'd5, 32'd5, 32'd5, 2'd2, 2'd3, 2'd0);
    run("R10", 32'd5, 32'd5, 32'd5, 2'd2, 2'd2, 2'd3);

    // R7: second start while busy is ignored
    e1 = model(32'd777, 32'd33, 32'd4444, 2'd1, 2'd0, 2'd2);
    exp_q.push_back(e1);
    tag_q.push_back("R7");
    @(negedge clk);
    hits = 32'd777; misses = 32'd33; cycles = 32'd4444;
    size_sel = 2'd1; ways_sel = 2'd0; line_sel = 2'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    hits = 32'd9; misses = 32'd9; cycles = 32'd9;
    size_sel = 2'd2; ways_sel = 2'd2; line_sel = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    chk(energy == e1, "R7", "result after busy start", energy, e1);
    chk(exp_q.size() == 0, "R7", "outstanding results", exp_q.size(), 0);

    // back-to-back after the ignored start
    run("R1", 32'd42, 32'd7, 32'd99, 2'd2, 2'd1, 2'd1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all results delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule